// File: doc/BRIEF.md
# Partitioned Parallel Block-Load Sequencer

This block schedules the loading of one partition's memory modules from a bank of parallel secondary-storage units. The machine has N = 2^N_LOG memory modules split among Q = 2^Q_LOG controller groups. Controller k owns the modules whose low Q_LOG address bits equal k. There are U = N/Q storage units, and unit i is wired to modules Q·i through Q·i+Q−1, one module in each controller group. A partition is described by a size exponent r, so it spans R = 2^r controllers and R·N/Q modules, and by the low-order bits that all of its controllers share.

A start pulse latches the partition descriptor. The block then presents one load step at a time. In each step it gives the physical module address that every storage unit writes, the logical number of the module served by unit 0, and the step index. Steps go out as a valid/ready stream: `step_valid` is the valid signal and `step_ack` is the ready signal from the storage side. A step is consumed on a clock edge where both are high. While `step_ack` is low the step and all its fields stay stable for as long as needed. `step_ack` has no effect when no step is offered.

In half mode only the lower half of the storage units exist, so the same partition takes twice as many steps. A descriptor that cannot name a legal controller set raises an error and produces no steps. Storage timing and data movement belong to the storage side.

Top module: `pbl_seq_top`

## Requirements
- R1: After reset `step_valid`, `busy`, `done` and `err` are all low.
- R2: A `start` pulse while no load is running latches `cfg_r`, `cfg_low` and `cfg_half`. If they are legal, `step_valid` is high from the next cycle with `step_idx` = 0. A `start` pulse while a load is running is ignored and the running schedule is unchanged.
- R3: `start` with `cfg_r` > Q_LOG, or with any set bit of `cfg_low` at position Q_LOG−`cfg_r` or above, sets `err` from the next cycle and offers no step. A later legal `start` clears `err`.
- R4: While `step_valid` is high and `step_ack` is low, `step_valid` stays high and every step field is unchanged on the next cycle.
- R5: A full-mode load offers exactly R = 2^r steps with indices 0..R−1. A half-mode load offers 2R steps with indices 0..2R−1. Each consumed step advances the index by one.
- R6: In full mode, in step g every unit i is enabled and writes physical module Q·i + `cfg_low` + g·2^(Q_LOG−r). Unit i's address sits at bits [i·N_LOG +: N_LOG] of `unit_addr`.
- R7: In half mode only units 0..U/2−1 are enabled. Steps s < R serve group g = s for unit i at Q·i + `cfg_low` + g·2^(Q_LOG−r). Steps s ≥ R serve g = s−R at Q·(i+U/2) + `cfg_low` + g·2^(Q_LOG−r). No unit is enabled while `step_valid` is low.
- R8: `log_base` is the logical number, that is physical address shifted right by Q_LOG−r, of the module written by unit 0: h·(U/2)·R + g, where h is 1 in the second half of a half-mode load and 0 otherwise.
- R9: `done` rises on the cycle after the last step is consumed. It stays high, with `step_valid` low, until the next `start`.
- R10: `step_ack` while no step is offered changes neither `done` nor the next schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Latch descriptor and begin a load |
| cfg_r | input | RW | Partition size exponent r |
| cfg_low | input | Q_LOG | Low-order bits shared by the partition's controllers |
| cfg_half | input | 1 | Half-population storage mode |
| step_valid | output | 1 | A step is offered |
| step_ack | input | 1 | Storage side consumes the offered step |
| step_idx | output | SW | Index of the offered step |
| unit_en | output | U | Per-unit write enable for this step |
| unit_addr | output | U·N_LOG | Per-unit physical module address, packed |
| log_base | output | N_LOG | Logical module number served by unit 0 |
| busy | output | 1 | A load is in progress |
| done | output | 1 | Last step consumed |
| err | output | 1 | Rejected descriptor |

## Verification
The bench uses the default build: 32 modules, 4 controller groups and 8 storage units. At this size every partition size from one to four controllers can be tested, as can every legal low-bit pattern for each size. Both halves of the half-population mapping can be seen, and the illegal cases of an oversized exponent and of low bits that overlap the group field can be driven. Back-pressure is applied by withholding the acknowledge every third cycle, so each step has to be held stable.

// File: rtl/pbl_pkg.sv
package pbl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2,
    ST_ERR  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/pbl_desc_check.sv
module pbl_desc_check #(
  parameter int Q_LOG = 2,
  parameter int RW    = 3
) (
  input  logic [RW-1:0]    cfg_r,
  input  logic [Q_LOG-1:0] cfg_low,
  output logic             desc_ok
);
  // Legal: r within group bits, and shared bits confined to the low q-r positions
  always_comb begin
    desc_ok = 1'b0;
    if (int'(cfg_r) <= Q_LOG)
      desc_ok = ((cfg_low >> (Q_LOG - int'(cfg_r))) == '0);
  end
endmodule

// File: rtl/pbl_seq_ctrl.sv
module pbl_seq_ctrl
  import pbl_pkg::*;
#(
  parameter int Q_LOG = 2,
  parameter int RW    = 3,
  parameter int SW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             desc_ok,
  input  logic [RW-1:0]    cfg_r,
  input  logic [Q_LOG-1:0] cfg_low,
  input  logic             cfg_half,
  input  logic             step_ack,
  output logic             step_valid,
  output logic [SW-1:0]    step_idx,
  output logic [RW-1:0]    lat_r,
  output logic [Q_LOG-1:0] lat_low,
  output logic             lat_half,
  output logic             busy,
  output logic             done,
  output logic             err
);
  seq_state_e       state_q;
  logic [SW-1:0]    idx_q;
  logic [SW-1:0]    last_idx;

  assign last_idx = ((SW'(1) << lat_r) << lat_half) - SW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      lat_r    <= '0;
      lat_low  <= '0;
      lat_half <= 1'b0;
    end else if (state_q != ST_RUN) begin
      if (start) begin
        if (desc_ok) begin
          state_q  <= ST_RUN;
          idx_q    <= '0;
          lat_r    <= cfg_r;
          lat_low  <= cfg_low;
          lat_half <= cfg_half;
        end else begin
          state_q  <= ST_ERR;
        end
      end
    end else if (step_ack) begin
      if (idx_q == last_idx) state_q <= ST_DONE;
      else                   idx_q   <= idx_q + SW'(1);
    end
  end

  assign step_valid = (state_q == ST_RUN);
  assign busy       = (state_q == ST_RUN);
  assign done       = (state_q == ST_DONE);
  assign err        = (state_q == ST_ERR);
  assign step_idx   = idx_q;

  // R2: accepted legal start offers step 0 next cycle
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !step_valid && desc_ok |=> step_valid && (step_idx == '0));
  // R4: back-pressure holds the step
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && !step_ack |=> step_valid && $stable(step_idx) && $stable(lat_low));
  // R3: error state offers nothing
  p_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !step_valid && !done);
  // R9: done persists until a new start
  p_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && !step_valid);
endmodule

// File: rtl/pbl_addr_gen.sv
module pbl_addr_gen #(
  parameter int N_LOG = 5,
  parameter int Q_LOG = 2,
  parameter int RW    = 3,
  parameter int SW    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_valid,
  input  logic [SW-1:0]      step_idx,
  input  logic [RW-1:0]      lat_r,
  input  logic [Q_LOG-1:0]   lat_low,
  input  logic               lat_half,
  output logic [(1<<(N_LOG-Q_LOG))-1:0]         unit_en,
  output logic [(1<<(N_LOG-Q_LOG))*N_LOG-1:0]   unit_addr,
  output logic [N_LOG-1:0]   log_base
);
  localparam int UW = N_LOG - Q_LOG;
  localparam int U  = 1 << UW;
  localparam int UH = U / 2;

  logic             upper;     // second half of a half-mode load
  logic [SW-1:0]    grp_step;  // step within the controller sweep
  logic [RW-1:0]    stride_sh;
  logic [Q_LOG-1:0] grp_off;   // controller-group position inside each unit's span
  logic [UW-1:0]    unit_bias;

  always_comb begin
    upper     = lat_half && ((step_idx >> lat_r) != '0);
    grp_step  = step_idx & ((SW'(1) << lat_r) - SW'(1));
    stride_sh = RW'(Q_LOG) - lat_r;
    grp_off   = lat_low + Q_LOG'(grp_step << stride_sh);
    unit_bias = upper ? UW'(UH) : '0;
    log_base  = (N_LOG'(unit_bias) << lat_r) + N_LOG'(grp_step);
  end

  for (genvar i = 0; i < U; i++) begin : g_unit
    localparam bit IN_LOW = (i < UH);
    logic [UW-1:0] unit_log;
    assign unit_log = UW'(i) + unit_bias;
    assign unit_addr[i*N_LOG +: N_LOG] = {unit_log, grp_off};
    assign unit_en[i] = step_valid && (IN_LOW || !lat_half);
  end

  // R7: unit 0 always serves an offered step
  p_en_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid |-> unit_en[0]);
  // R7: nothing enabled when no step is offered
  p_idle_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !step_valid |-> (unit_en == '0));
  // R8: first step always starts at logical module 0
  p_lb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && (step_idx == '0) |-> (log_base == '0));
endmodule

// File: rtl/pbl_seq_top.sv
module pbl_seq_top #(
  parameter int N_LOG = 5,
  parameter int Q_LOG = 2,
  localparam int U    = 1 << (N_LOG - Q_LOG),
  localparam int RW   = $clog2(Q_LOG + 1) + 1,
  localparam int SW   = Q_LOG + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [RW-1:0]      cfg_r,
  input  logic [Q_LOG-1:0]   cfg_low,
  input  logic               cfg_half,
  output logic               step_valid,
  input  logic               step_ack,
  output logic [SW-1:0]      step_idx,
  output logic [U-1:0]       unit_en,
  output logic [U*N_LOG-1:0] unit_addr,
  output logic [N_LOG-1:0]   log_base,
  output logic               busy,
  output logic               done,
  output logic               err
);
  logic             desc_ok;
  logic [RW-1:0]    lat_r;
  logic [Q_LOG-1:0] lat_low;
  logic             lat_half;

  pbl_desc_check #(.Q_LOG(Q_LOG), .RW(RW)) u_chk (
    .cfg_r(cfg_r), .cfg_low(cfg_low), .desc_ok(desc_ok)
  );

  pbl_seq_ctrl #(.Q_LOG(Q_LOG), .RW(RW), .SW(SW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .desc_ok(desc_ok),
    .cfg_r(cfg_r), .cfg_low(cfg_low), .cfg_half(cfg_half),
    .step_ack(step_ack), .step_valid(step_valid), .step_idx(step_idx),
    .lat_r(lat_r), .lat_low(lat_low), .lat_half(lat_half),
    .busy(busy), .done(done), .err(err)
  );

  pbl_addr_gen #(.N_LOG(N_LOG), .Q_LOG(Q_LOG), .RW(RW), .SW(SW)) u_addr (
    .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .step_idx(step_idx),
    .lat_r(lat_r), .lat_low(lat_low), .lat_half(lat_half),
    .unit_en(unit_en), .unit_addr(unit_addr), .log_base(log_base)
  );
endmodule

// File: tb/pbl_seq_top_tb_top.sv
module pbl_seq_top_tb_top;
  localparam int N_LOG = 5;
  localparam int Q_LOG = 2;
  localparam int Q     = 1 << Q_LOG;
  localparam int U     = 1 << (N_LOG - Q_LOG);
  localparam int RW    = $clog2(Q_LOG + 1) + 1;
  localparam int SW    = Q_LOG + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [RW-1:0] cfg_r = '0;
  logic [Q_LOG-1:0] cfg_low = '0;
  logic cfg_half = 1'b0;
  logic step_valid, step_ack = 1'b0;
  logic [SW-1:0] step_idx;
  logic [U-1:0] unit_en;
  logic [U*N_LOG-1:0] unit_addr;
  logic [N_LOG-1:0] log_base;
  logic busy, done, err;

  always #10 clk = ~clk;

  pbl_seq_top #(.N_LOG(N_LOG), .Q_LOG(Q_LOG)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_r(cfg_r), .cfg_low(cfg_low),
    .cfg_half(cfg_half), .step_valid(step_valid), .step_ack(step_ack),
    .step_idx(step_idx), .unit_en(unit_en), .unit_addr(unit_addr),
    .log_base(log_base), .busy(busy), .done(done), .err(err)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit fin = 1'b0;
  bit idle_ack = 1'b0;
  int ack_cnt = 0;

  int q_idx[$];
  int q_lb[$];
  logic [U-1:0] q_en[$];
  int q_addr[$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor: compares the offered step with the scoreboard, drives ready
  always @(negedge clk) begin
    if (rst_n && step_valid) begin
      if (q_idx.size() == 0) begin
        chk(1'b0, "R5", "unexpected step", int'(step_idx), -1);
        step_ack = 1'b1;
      end else begin
        chk(int'(step_idx) == q_idx[0], "R5", "step_idx", int'(step_idx), q_idx[0]);
        chk(unit_en == q_en[0], "R7", "unit_en", int'(unit_en), int'(q_en[0]));
        for (int i = 0; i < U; i++)
          if (q_en[0][i])
            chk(int'(unit_addr[i*N_LOG +: N_LOG]) == q_addr[i], "R6", $sformatf("unit %0d addr", i),
                int'(unit_addr[i*N_LOG +: N_LOG]), q_addr[i]);
        chk(int'(log_base) == q_lb[0], "R8", "log_base", int'(log_base), q_lb[0]);
        step_ack = ((ack_cnt % 3) != 2);  // R4: stall every third cycle
        ack_cnt++;
        if (step_ack) begin
          void'(q_idx.pop_front());
          void'(q_lb.pop_front());
          void'(q_en.pop_front());
          for (int i = 0; i < U; i++) void'(q_addr.pop_front());
        end
      end
    end else begin
      step_ack = idle_ack;
    end
  end

  // Driver: pushes the expected schedule, then starts the load
  task automatic run_desc(input int r, input int low, input bit half, input bit poke);
    int rr = 1 << r;
    int steps = rr * (half ? 2 : 1);
    for (int s = 0; s < steps; s++) begin
      int h = half ? s / rr : 0;
      int g = s % rr;
      logic [U-1:0] en;
      for (int i = 0; i < U; i++) begin
        en[i] = !half || (i < U/2);
        q_addr.push_back(Q * (i + h * (U/2)) + low + g * (Q / rr));
      end
      q_idx.push_back(s);
      q_en.push_back(en);
      q_lb.push_back(h * (U/2) * rr + g);
    end
    @(negedge clk);
    start = 1'b1; cfg_r = RW'(r); cfg_low = Q_LOG'(low); cfg_half = half;
    @(negedge clk);
    start = 1'b0;
    chk(step_valid === 1'b1, "R2", "step_valid after start", int'(step_valid), 1);
    chk(err === 1'b0, "R3", "err cleared by legal start", int'(err), 0);
    if (poke) begin
      @(negedge clk);
      start = 1'b1; cfg_r = '0; cfg_low = '1; cfg_half = 1'b1;  // R2: ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    while (q_idx.size() != 0) @(posedge clk);
    @(negedge clk);
    chk(done === 1'b1, "R9", "done after last step", int'(done), 1);
    chk(step_valid === 1'b0, "R9", "no step after done", int'(step_valid), 0);
    repeat (2) @(negedge clk);
    chk(done === 1'b1, "R9", "done held", int'(done), 1);
  endtask

  task automatic run_err(input int r, input int low);
    @(negedge clk);
    start = 1'b1; cfg_r = RW'(r); cfg_low = Q_LOG'(low); cfg_half = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk(err === 1'b1, "R3", "err raised", int'(err), 1);
    repeat (3) @(negedge clk);
    chk(step_valid === 1'b0, "R3", "no step on bad descriptor", int'(step_valid), 0);
    chk(busy === 1'b0, "R3", "not busy on bad descriptor", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(step_valid === 1'b0, "R1", "reset step_valid", int'(step_valid), 0);
    chk(busy === 1'b0, "R1", "reset busy", int'(busy), 0);
    chk(done === 1'b0, "R1", "reset done", int'(done), 0);
    chk(err === 1'b0, "R1", "reset err", int'(err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(step_valid === 1'b0 && done === 1'b0, "R1", "idle after reset", int'(step_valid), 0);

    run_desc(1, 0, 1'b0, 1'b0);   // controllers 0 and 2: 0,4..28 then 2,6..30
    run_desc(1, 1, 1'b0, 1'b0);
    run_desc(0, 3, 1'b0, 1'b0);
    run_desc(2, 0, 1'b0, 1'b1);   // R2 start ignored mid-run
    run_desc(1, 1, 1'b1, 1'b0);   // half mode
    run_desc(2, 0, 1'b1, 1'b0);
    run_err(3, 0);
    run_err(1, 2);
    run_err(2, 1);
    run_desc(0, 0, 1'b0, 1'b0);   // recovery from error

    // R10: acknowledge with nothing offered
    idle_ack = 1'b1;
    repeat (3) @(negedge clk);
    chk(done === 1'b1, "R10", "done unchanged by idle ack", int'(done), 1);
    chk(step_valid === 1'b0, "R10", "no step from idle ack", int'(step_valid), 0);
    idle_ack = 1'b0;
    run_desc(1, 0, 1'b0, 1'b0);

    fin = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!fin) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule